// File: doc/BRIEF.md
# Template Hit-Quality Scoring Engine

The engine rates how well one 8x8 tile of 8-bit pixels matches a target template. A template is two one-bit masks over the same tile. The bright mask marks where the target should appear light. The surround mask marks the ring around it that should appear dark. Pixel rows and mask rows are written into the engine one row per beat through a valid/ready port. A start pulse then runs a fixed sequence of steps and ends with a single-cycle done pulse and a fixed-point score.

The sequence has four steps. First it adds up the pixels that lie under the bright mask. Next it sets an adaptive threshold: the integer mean of those pixels, as normalised by a run-time bright count, minus a programmable bias, clamped to the pixel range. It then makes a second pass over the rows and counts two things: bright-mask pixels at or above the threshold, and surround-mask pixels strictly below it. Last, it divides each count by its own normaliser and averages the two ratios.

Each row is reduced by a three-level pairwise adder tree. All divisions share one bit-serial divider.

Top module: `tmpl_hit_scorer`

## Requirements
- R1: `in_ready` is high exactly when the engine is idle. Each accepted beat writes one row at an internal row pointer. The pointer starts at 0 after reset, advances by one per accepted beat and wraps from 7 back to 0. Within a beat, column c takes its pixel from `in_pix[8c+7:8c]`, and its mask bits from bit c of `in_bmask` and of `in_smask`.
- R2: For each run, S is the sum of all pixels whose bright bit is set. The threshold is floor(S / `cfg_bc`) minus `cfg_bias`.
- R3: B counts the bright-mask positions whose pixel is greater than or equal to the threshold.
- R4: U counts the surround-mask positions whose pixel is strictly less than the threshold.
- R5: `score` = floor((floor(B*256/`cfg_bc`) + floor(U*256/`cfg_sc`)) / 2). It is unsigned and has 8 fractional bits.
- R6: `cfg_bias`, `cfg_bc` and `cfg_sc` are sampled on the start cycle. A start pulse while `busy` is high has no effect.
- R7: `done` is high for exactly one cycle per accepted start. `score` changes only on a cycle where `done` is high, and otherwise holds its value.
- R8: If `cfg_bc` or `cfg_sc` is zero at start, the engine skips the computation. On the next cycle it raises `done` with `err` = 1 and `score` = 0. The next accepted start clears `err`.
- R9: The threshold is computed signed and clamped to the range 0 to 255 before any comparison. A bias larger than the mean therefore gives a threshold of 0, and a mean above 255 gives a threshold of 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Row beat valid |
| in_ready | output | 1 | Row beat accepted when high (idle) |
| in_pix | input | 64 | Eight pixels of one row, column c at bits 8c+7:8c |
| in_bmask | input | 8 | Bright-mask bits of the row, bit c = column c |
| in_smask | input | 8 | Surround-mask bits of the row, bit c = column c |
| cfg_bias | input | 8 | Threshold bias subtracted from the mean |
| cfg_bc | input | 7 | Bright normaliser |
| cfg_sc | input | 7 | Surround normaliser |
| start | input | 1 | Start pulse, honoured only when idle |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run had a zero normaliser |
| score | output | 16 | Hit quality, 8 fractional bits |

## Verification
The bench scores random tiles with random masks, with the normalisers set both to the true mask populations and to unrelated values. This separates errors in the sum, in the comparisons and in the division. A directed tile with a bias above the mean drives the threshold clamp to zero, so every bright pixel counts and no surround pixel does. A saturated tile with a bright normaliser of 1 drives the clamp to 255. This exposes both the greater-or-equal boundary and the strict less-than boundary. Further directed runs cover the zero-normaliser error path, a start issued mid-run that carries a zero normaliser while junk rows are offered, and a ninth row load that must overwrite row 0.

// File: rtl/hqs_pkg.sv
`timescale 1ns/1ps
package hqs_pkg;
    localparam int TILE_DIM  = 8;
    localparam int PIXEL_W   = 8;
    localparam int FRAC_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SUM,
        ST_TH_GO,
        ST_TH_WAIT,
        ST_CNT,
        ST_RB_GO,
        ST_RB_WAIT,
        ST_RS_GO,
        ST_RS_WAIT
    } hqs_state_e;
endpackage

// File: rtl/hqs_row_tree.sv
`timescale 1ns/1ps
// Pairwise reduction of one row: level s adds neighbours 2k and 2k+1.
module hqs_row_tree #(
    parameter int N     = 8,
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + $clog2(N)
) (
    input  logic [N-1:0][IN_W-1:0] vals,
    output logic [OUT_W-1:0]       total
);
    localparam int LV = $clog2(N);

    logic [OUT_W-1:0] lvl [LV+1][N];

    for (genvar k = 0; k < N; k++) begin : g_leaf
        assign lvl[0][k] = OUT_W'(vals[k]);
    end

    for (genvar s = 0; s < LV; s++) begin : g_lvl
        for (genvar k = 0; k < N; k++) begin : g_node
            if (k < (N >> (s + 1))) begin : g_add
                assign lvl[s+1][k] = lvl[s][2*k] + lvl[s][2*k+1];
            end else begin : g_pad
                assign lvl[s+1][k] = '0;
            end
        end
    end

    assign total = lvl[LV][0];
endmodule

// File: rtl/hqs_divider.sv
`timescale 1ns/1ps
// Restoring bit-serial divider: quo = floor((num << FRAC_W) / den).
module hqs_divider #(
    parameter int NUM_W  = 14,
    parameter int DEN_W  = 7,
    parameter int FRAC_W = 8,
    parameter int QUO_W  = NUM_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [QUO_W-1:0] quo
);
    localparam int CNT_W = $clog2(QUO_W + 1);

    typedef struct packed {
        logic [QUO_W-1:0] work;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [QUO_W-1:0] quo;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             fin;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] rsh;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        rsh   = {q.rem, q.work[QUO_W-1]};
        if (go) begin
            d.work = {num, {FRAC_W{1'b0}}};
            d.rem  = '0;
            d.quo  = '0;
            d.den  = den;
            d.cnt  = CNT_W'(QUO_W);
            d.run  = 1'b1;
        end else if (q.run) begin
            if (rsh >= {1'b0, q.den}) begin
                d.rem = DEN_W'(rsh - {1'b0, q.den});
                d.quo = {q.quo[QUO_W-2:0], 1'b1};
            end else begin
                d.rem = rsh[DEN_W-1:0];
                d.quo = {q.quo[QUO_W-2:0], 1'b0};
            end
            d.work = q.work << 1;
            d.cnt  = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
    assign quo = q.quo;

    // R5
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin |-> (q.rem < q.den));
endmodule

// File: rtl/tmpl_hit_scorer.sv
`timescale 1ns/1ps
module tmpl_hit_scorer #(
    parameter int DIM    = hqs_pkg::TILE_DIM,
    parameter int PIX_W  = hqs_pkg::PIXEL_W,
    parameter int FRAC_W = hqs_pkg::FRAC_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [DIM*PIX_W-1:0]   in_pix,
    input  logic [DIM-1:0]         in_bmask,
    input  logic [DIM-1:0]         in_smask,
    input  logic [PIX_W-1:0]       cfg_bias,
    input  logic [$clog2(DIM*DIM+1)-1:0] cfg_bc,
    input  logic [$clog2(DIM*DIM+1)-1:0] cfg_sc,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [2*FRAC_W-1:0]    score
);
    import hqs_pkg::*;

    localparam int RIDX_W  = $clog2(DIM);
    localparam int CNT_W   = $clog2(DIM*DIM + 1);
    localparam int SUM_W   = PIX_W + $clog2(DIM*DIM);
    localparam int ROW_W   = PIX_W + $clog2(DIM);
    localparam int BIT_W   = 1 + $clog2(DIM);
    localparam int QUO_W   = SUM_W + FRAC_W;
    localparam int SCORE_W = 2 * FRAC_W;
    localparam int THS_W   = SUM_W + 2;
    localparam logic signed [THS_W-1:0] TH_MAX = THS_W'((1 << PIX_W) - 1);

    typedef struct packed {
        hqs_state_e                         st;
        logic [RIDX_W-1:0]                  row;
        logic [RIDX_W-1:0]                  ld_row;
        logic [DIM-1:0][DIM-1:0][PIX_W-1:0] pix;
        logic [DIM-1:0][DIM-1:0]            bm;
        logic [DIM-1:0][DIM-1:0]            sm;
        logic [SUM_W-1:0]                   shape;
        logic [PIX_W-1:0]                   th;
        logic [CNT_W-1:0]                   bcnt;
        logic [CNT_W-1:0]                   scnt;
        logic [SCORE_W-1:0]                 rb;
        logic [SCORE_W-1:0]                 score;
        logic [PIX_W-1:0]                   bias;
        logic [CNT_W-1:0]                   bc;
        logic [CNT_W-1:0]                   sc;
        logic                               done;
        logic                               err;
    } eng_t;

    eng_t q, d;

    logic [DIM-1:0][PIX_W-1:0] masked_row;
    logic [DIM-1:0]            bright_hit, surr_hit;
    logic [ROW_W-1:0]          row_sum;
    logic [BIT_W-1:0]          bright_row_cnt, surr_row_cnt;
    logic                      div_go, div_fin;
    logic [SUM_W-1:0]          div_num;
    logic [CNT_W-1:0]          div_den;
    logic [QUO_W-1:0]          div_quo;
    logic signed [THS_W-1:0]   th_s;

    // Per-column selection for the current row.
    always_comb begin
        for (int c = 0; c < DIM; c++) begin
            masked_row[c] = q.bm[q.row][c] ? q.pix[q.row][c] : '0;
            bright_hit[c] = q.bm[q.row][c] && (q.pix[q.row][c] >= q.th);
            surr_hit[c]   = q.sm[q.row][c] && (q.pix[q.row][c] <  q.th);
        end
    end

    hqs_row_tree #(.N(DIM), .IN_W(PIX_W), .OUT_W(ROW_W)) i_sum_tree (
        .vals(masked_row), .total(row_sum));
    hqs_row_tree #(.N(DIM), .IN_W(1), .OUT_W(BIT_W)) i_bright_tree (
        .vals(bright_hit), .total(bright_row_cnt));
    hqs_row_tree #(.N(DIM), .IN_W(1), .OUT_W(BIT_W)) i_surr_tree (
        .vals(surr_hit), .total(surr_row_cnt));

    // Divider operand selection per launch state.
    always_comb begin
        div_go  = (q.st == ST_TH_GO) || (q.st == ST_RB_GO) || (q.st == ST_RS_GO);
        div_num = q.shape;
        div_den = q.bc;
        if (q.st == ST_RB_GO) begin
            div_num = SUM_W'(q.bcnt);
        end else if (q.st == ST_RS_GO) begin
            div_num = SUM_W'(q.scnt);
            div_den = q.sc;
        end
    end

    hqs_divider #(.NUM_W(SUM_W), .DEN_W(CNT_W), .FRAC_W(FRAC_W), .QUO_W(QUO_W)) i_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
        .fin(div_fin), .quo(div_quo));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        th_s   = $signed({2'b00, div_quo[QUO_W-1:FRAC_W]})
               - $signed(THS_W'(q.bias));

        if (in_valid && (q.st == ST_IDLE)) begin
            d.pix[q.ld_row] = in_pix;
            d.bm[q.ld_row]  = in_bmask;
            d.sm[q.ld_row]  = in_smask;
            d.ld_row = (q.ld_row == RIDX_W'(DIM - 1)) ? '0 : q.ld_row + RIDX_W'(1);
        end

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.bias = cfg_bias;
                    d.bc   = cfg_bc;
                    d.sc   = cfg_sc;
                    d.err  = 1'b0;
                    if ((cfg_bc == '0) || (cfg_sc == '0)) begin
                        d.err   = 1'b1;
                        d.score = '0;
                        d.done  = 1'b1;
                    end else begin
                        d.st    = ST_SUM;
                        d.row   = '0;
                        d.shape = '0;
                        d.bcnt  = '0;
                        d.scnt  = '0;
                    end
                end
            end
            ST_SUM: begin
                d.shape = q.shape + SUM_W'(row_sum);
                if (q.row == RIDX_W'(DIM - 1)) begin
                    d.row = '0;
                    d.st  = ST_TH_GO;
                end else begin
                    d.row = q.row + RIDX_W'(1);
                end
            end
            ST_TH_GO: d.st = ST_TH_WAIT;
            ST_TH_WAIT: begin
                if (div_fin) begin
                    if (th_s < 0)           d.th = '0;
                    else if (th_s > TH_MAX) d.th = '1;
                    else                    d.th = th_s[PIX_W-1:0];
                    d.st = ST_CNT;
                end
            end
            ST_CNT: begin
                d.bcnt = q.bcnt + CNT_W'(bright_row_cnt);
                d.scnt = q.scnt + CNT_W'(surr_row_cnt);
                if (q.row == RIDX_W'(DIM - 1)) begin
                    d.row = '0;
                    d.st  = ST_RB_GO;
                end else begin
                    d.row = q.row + RIDX_W'(1);
                end
            end
            ST_RB_GO: d.st = ST_RB_WAIT;
            ST_RB_WAIT: begin
                if (div_fin) begin
                    d.rb = div_quo[SCORE_W-1:0];
                    d.st = ST_RS_GO;
                end
            end
            ST_RS_GO: d.st = ST_RS_WAIT;
            ST_RS_WAIT: begin
                if (div_fin) begin
                    d.score = SCORE_W'(({1'b0, q.rb} + {1'b0, div_quo[SCORE_W-1:0]}) >> 1);
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready = (q.st == ST_IDLE);
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign score    = q.score;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R7
    score_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> $stable(q.score));
    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.err) |-> (q.score == '0));
    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> ($stable(q.bc) && $stable(q.sc) && $stable(q.bias)));
    // R1
    load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.ld_row));
endmodule

// File: tb/test_tmpl_hit_scorer.sv
`timescale 1ns/1ps
module test_tmpl_hit_scorer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_pix = '0;
    logic [7:0]  in_bmask = '0;
    logic [7:0]  in_smask = '0;
    logic [7:0]  cfg_bias = '0;
    logic [6:0]  cfg_bc = '0;
    logic [6:0]  cfg_sc = '0;
    logic        start = 1'b0;
    logic        busy, done, err;
    logic [15:0] score;

    int total = 0;
    int bad = 0;

    logic [63:0] m_pix [8];
    logic [7:0]  m_bm  [8];
    logic [7:0]  m_sm  [8];
    int          m_ptr = 0;

    always #10 clk = ~clk;

    tmpl_hit_scorer i_tmpl_hit_scorer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_bmask(in_bmask), .in_smask(in_smask),
        .cfg_bias(cfg_bias), .cfg_bc(cfg_bc), .cfg_sc(cfg_sc), .start(start),
        .busy(busy), .done(done), .err(err), .score(score));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_score(input int bias, input int bc, input int sc);
        int s = 0, th, b = 0, u = 0, rb, rs, p;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if (m_bm[r][c]) s += int'(m_pix[r][c*8 +: 8]);
        th = s / bc - bias;
        if (th < 0) th = 0;
        if (th > 255) th = 255;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                p = int'(m_pix[r][c*8 +: 8]);
                if (m_bm[r][c] && p >= th) b++;
                if (m_sm[r][c] && p < th) u++;
            end
        rb = (b * 256) / bc;
        rs = (u * 256) / sc;
        return (rb + rs) / 2;
    endfunction

    function automatic int pop_all(input bit bright);
        int n = 0;
        for (int r = 0; r < 8; r++)
            n += bright ? $countones(m_bm[r]) : $countones(m_sm[r]);
        return n;
    endfunction

    // R1: one beat, model pointer mirrors the required wrap.
    task automatic load_row(input logic [63:0] p, input logic [7:0] b, input logic [7:0] s);
        @(negedge clk);
        in_valid = 1'b1; in_pix = p; in_bmask = b; in_smask = s;
        @(negedge clk);
        in_valid = 1'b0;
        m_pix[m_ptr] = p; m_bm[m_ptr] = b; m_sm[m_ptr] = s;
        m_ptr = (m_ptr + 1) % 8;
    endtask

    task automatic run_case(input int bias, input int bc, input int sc,
                            input bit intrude, input string req);
        int expv, n;
        bit experr;
        logic [15:0] held;
        experr = (bc == 0) || (sc == 0);
        expv   = experr ? 0 : model_score(bias, bc, sc);
        @(negedge clk);
        cfg_bias = 8'(bias); cfg_bc = 7'(bc); cfg_sc = 7'(sc); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!experr) begin
            chk(busy == 1'b1, "R6 busy after start", busy, 1);
            chk(in_ready == 1'b0, "R1 ready low while busy", in_ready, 0);
        end
        n = 0;
        while (!done && n < 400) begin
            if (intrude && n == 3) begin
                // R6: start with a zero normaliser plus junk row while busy
                start = 1'b1; cfg_bc = '0; in_valid = 1'b1;
                in_pix = {8{8'hA5}}; in_bmask = 8'hFF; in_smask = 8'hFF;
            end else begin
                start = 1'b0; in_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0; in_valid = 1'b0;
        chk(done == 1'b1, {req, " done seen"}, done, 1);
        if (experr) chk(n == 0, "R8 done latency", n, 0);
        chk(score == 16'(expv), {req, " score"}, score, expv);
        chk(err == experr, {req, " err"}, err, experr);
        held = score;
        @(negedge clk);
        chk(done == 1'b0, "R7 done width", done, 0);
        repeat (4) @(negedge clk);
        chk(score == held, "R7 score hold", score, held);
    endtask

    task automatic rand_window();
        logic [63:0] p;
        logic [7:0] b, s;
        for (int r = 0; r < 8; r++) begin
            p = {$urandom, $urandom};
            b = 8'($urandom) & 8'($urandom);
            s = 8'($urandom) & ~b;
            load_row(p, b, s);
        end
        if (pop_all(1'b1) == 0) load_row(m_pix[m_ptr], 8'h01, 8'h00);
    endtask

    initial begin
        #(64'd20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int bc, sc;
        void'($urandom(32'd90417));
        for (int r = 0; r < 8; r++) begin m_pix[r] = '0; m_bm[r] = '0; m_sm[r] = '0; end
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        chk(busy == 1'b0, "R6 reset busy", busy, 0);
        chk(done == 1'b0, "R7 reset done", done, 0);
        chk(score == 16'd0, "R7 reset score", score, 0);
        chk(err == 1'b0, "R8 reset err", err, 0);
        rst_n = 1'b1;

        // Random tiles, normalisers equal to populations: R2 R3 R4 R5
        for (int i = 0; i < 12; i++) begin
            rand_window();
            bc = pop_all(1'b1);
            sc = pop_all(1'b0);
            if (sc == 0) sc = 1;
            run_case(int'($urandom_range(0, 40)), bc, sc, 1'b0, "R2 R3 R4 R5 random");
        end
        // Unrelated normalisers: R5
        for (int i = 0; i < 6; i++) begin
            rand_window();
            run_case(int'($urandom_range(0, 255)), int'($urandom_range(1, 64)),
                     int'($urandom_range(1, 64)), 1'b0, "R5 free normalisers");
        end

        // R9 low clamp: dim tile, bias above mean -> every bright pixel hits
        for (int r = 0; r < 8; r++) load_row({8{8'd20}}, 8'h3C, 8'hC3);
        run_case(255, 32, 32, 1'b0, "R9 low clamp");
        chk(score == 16'h0080, "R9 low clamp literal", score, 16'h0080);

        // R9 high clamp: all 255, bc=1 -> threshold 255, bright >= keeps 18, surround 0
        for (int r = 0; r < 8; r++) load_row({8{8'hFF}}, 8'h00, 8'h00);
        load_row({8{8'hFF}}, 8'hFF, 8'h00);
        load_row({8{8'hFF}}, 8'hFF, 8'hFF);
        load_row({8{8'hFF}}, 8'h03, 8'hFF);
        run_case(0, 1, 16, 1'b0, "R3 R4 R9 high clamp");
        chk(score == 16'd2304, "R9 high clamp literal", score, 2304);

        // R8 zero normalisers, then recovery
        run_case(0, 0, 5, 1'b0, "R8 zero bc");
        run_case(0, 5, 0, 1'b0, "R8 zero sc");
        rand_window();
        run_case(10, pop_all(1'b1), 9, 1'b0, "R8 err cleared");

        // R6 start and load attempts while busy are ignored
        rand_window();
        run_case(5, pop_all(1'b1), 11, 1'b1, "R6 busy start ignored");

        // R1 ninth beat overwrites row 0
        rand_window();
        load_row({8{8'd200}}, 8'hFF, 8'h00);
        run_case(0, pop_all(1'b1), 7, 1'b0, "R1 pointer wrap");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule